// File: doc/BRIEF.md
# Instruction and Stack Pointer Adjuster

This block holds the 64-bit instruction pointer and stack pointer registers of a processor core. It moves either one by a signed amount. A request names one of the two pointers and supplies a two's-complement delta. The block adds the delta at the width that the current operating mode selects and checks the result against the rules of that mode. One clock later it returns the new pointer value and an error flag.

When the core runs in 64-bit operation, the full 64-bit sum is checked for canonical form. In any other mode, legacy protected or compatibility, the pointer is either 16 or 32 bits wide, as the default-size attribute of the code or stack segment selects. The narrow sum wraps at that width. It is then checked against the segment limit, and an expand-down segment reverses the sense of the check. A result that passes is written back when the request asks for it. A narrow write replaces only the low bits of the 64-bit register.

The surrounding pipeline uses the block to advance the instruction pointer past a fetched instruction, to apply relative branches, and to move the stack pointer for pushes and pops. It reads the error flag to raise a fault.

Top module: `ptr_adjuster`

## Requirements
- R1: For every cycle with `req_valid_i` high, `res_valid_o` is high in the next cycle, and only then. `res_ptr_o` and `res_err_o` belong to that request.
- R2: 64-bit operation applies when `long_mode_i` and `cs_long_i` are both 1. The delta is sign-extended, the addition is carried out at 64 bits, and `res_ptr_o` is the full 64-bit sum. Negative deltas move the pointer down. With `long_mode_i`=1 and `cs_long_i`=0 (compatibility), the narrow rules of R4 to R7 apply.
- R3: In 64-bit operation, `res_err_o` is 1 exactly when bits 63 down to 47 of the sum are not all equal.
- R4: In narrow operation with `req_sel_i`=0 (instruction pointer), the width is 32 bits when `cs_wide_i`=1 and 16 bits when it is 0. The sum of the low bits wraps modulo that width, and `res_ptr_o` is the wrapped value zero-extended.
- R5: In narrow operation with `req_sel_i`=1 (stack pointer), the width is 32 bits when `ss_wide_i`=1 and 16 bits when it is 0. Wrapping and zero-extension are as in R4.
- R6: For a segment whose expand-down input is 0, the narrow result is an error exactly when it is greater than the segment limit. A result equal to the limit is accepted.
- R7: For a segment whose expand-down input is 1, the narrow result is accepted exactly when it is greater than the limit and no greater than 0xFFFF (16-bit width) or 0xFFFFFFFF (32-bit width).
- R8: When `req_wr_i`=1 and there is no error, the selected register takes the result at the same edge that presents the response. A 64-bit result replaces all 64 bits. A narrow result replaces only the low 32 or 16 bits and keeps the rest.
- R9: A request with an error, or with `req_wr_i`=0, leaves both registers unchanged. Neither register changes in a cycle that follows one without a request.
- R10: After reset, `ip_o` equals `RIP_RST`, `sp_o` equals `RSP_RST`, and `res_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| long_mode_i | input | 1 | Long addressing mode active |
| cs_long_i | input | 1 | Code segment runs 64-bit code |
| cs_wide_i | input | 1 | Code segment default size is 32 bits |
| ss_wide_i | input | 1 | Stack segment default size is 32 bits |
| cs_limit_i | input | 32 | Code segment limit |
| cs_expdn_i | input | 1 | Code segment is expand-down |
| ss_limit_i | input | 32 | Stack segment limit |
| ss_expdn_i | input | 1 | Stack segment is expand-down |
| req_valid_i | input | 1 | Request strobe |
| req_sel_i | input | 1 | 0 selects instruction pointer, 1 selects stack pointer |
| req_delta_i | input | DELTA_W | Signed amount to add |
| req_wr_i | input | 1 | Commit the result if it is error-free |
| res_valid_o | output | 1 | Response strobe |
| res_ptr_o | output | ADDR_W | New pointer value |
| res_err_o | output | 1 | Limit or canonical error |
| ip_o | output | ADDR_W | Current instruction pointer register |
| sp_o | output | ADDR_W | Current stack pointer register |

## Verification
A register that is updated wrongly shows on `ip_o` or `sp_o` one cycle after the offending request. It also corrupts the `res_ptr_o` of every later request on that pointer, because each sum starts from the stored value. Several faults show only in the upper bits: a narrow write that clobbers those bits, or a wrong mode decode that adds at the wrong width. The stimulus therefore starts the registers with nonzero upper halves and switches between narrow and 64-bit operation. An error that commits anyway, or a missing commit, shows in the next cycle as a register that differs from the value the model holds.

// File: rtl/ptr_adj_pkg.sv
// Package: shared constants and the pointer selector encoding for the
// pointer adjuster. Assumes two architectural pointers.
package ptr_adj_pkg;
    typedef enum logic {
        PSEL_IP = 1'b0,
        PSEL_SP = 1'b1
    } ptr_sel_e;

    localparam int NUM_PTRS = 2;
endpackage

// File: rtl/ptr_seg_check.sv
// Module: ptr_seg_check
// Decides whether a narrow offset lies inside a segment. A normal segment
// spans 0..limit. An expand-down segment spans limit+1 .. top, and the top
// is all ones at either the wide or the half width.
// Assumes offs_i is already wrapped to the active width.
module ptr_seg_check #(
    parameter int SEG_W  = 32,
    parameter int HALF_W = 16
) (
    input  logic [SEG_W-1:0] offs_i,
    input  logic [SEG_W-1:0] limit_i,
    input  logic             expdn_i,
    input  logic             wide_i,
    output logic             inside_o
);
    localparam logic [SEG_W-1:0] TOP_WIDE = {SEG_W{1'b1}};
    localparam logic [SEG_W-1:0] TOP_HALF = {{(SEG_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

    logic [SEG_W-1:0] seg_top;

    // Purpose: pick the segment top and compare the offset with the bounds.
    always_comb begin
        seg_top = wide_i ? TOP_WIDE : TOP_HALF;
        if (expdn_i) begin
            inside_o = (offs_i > limit_i) && (offs_i <= seg_top);
        end else begin
            inside_o = (offs_i <= limit_i);
        end
    end
endmodule

// File: rtl/ptr_canon_check.sv
// Module: ptr_canon_check
// Reports whether a full-width address is canonical, meaning that every bit
// from the top implemented virtual-address bit upward is equal.
// Assumes VA_BITS < ADDR_W.
module ptr_canon_check #(
    parameter int ADDR_W  = 64,
    parameter int VA_BITS = 48
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              canon_o
);
    localparam int HI_W = ADDR_W - VA_BITS + 1;

    logic [HI_W-1:0] hi_bits;

    // Purpose: the upper bits must be all zeros or all ones.
    always_comb begin
        hi_bits = addr_i[ADDR_W-1:VA_BITS-1];
        canon_o = (&hi_bits) || !(|hi_bits);
    end
endmodule

// File: rtl/ptr_next_calc.sv
// Module: ptr_next_calc
// Computes the next value of one pointer. A single full-width adder serves
// every mode, and the 32-bit and 16-bit sums are its low bits, which are
// equal to a modular add at those widths. The module produces the value
// returned to the requester, the value to merge into the register, and the
// error flag. Assumes DELTA_W <= ADDR_W and HALF_W < SEG_W < ADDR_W.
module ptr_next_calc #(
    parameter int ADDR_W  = 64,
    parameter int DELTA_W = 64,
    parameter int SEG_W   = 32,
    parameter int HALF_W  = 16,
    parameter int VA_BITS = 48
) (
    input  logic [ADDR_W-1:0]  cur_i,
    input  logic [DELTA_W-1:0] delta_i,
    input  logic               mode64_i,
    input  logic               wide_i,
    input  logic [SEG_W-1:0]   limit_i,
    input  logic               expdn_i,
    output logic [ADDR_W-1:0]  ret_o,
    output logic [ADDR_W-1:0]  merged_o,
    output logic               err_o
);
    localparam int PAD_W = ADDR_W - DELTA_W;

    logic [ADDR_W-1:0] delta_x;
    logic [ADDR_W-1:0] sum_full;
    logic [SEG_W-1:0]  narrow_off;
    logic              seg_inside;
    logic              canon;

    // Sign-extend the delta only when it is narrower than the register.
    if (PAD_W > 0) begin : g_delta_ext
        assign delta_x = {{PAD_W{delta_i[DELTA_W-1]}}, delta_i};
    end else begin : g_delta_full
        assign delta_x = delta_i[ADDR_W-1:0];
    end

    // Purpose: the shared full-width adder and the narrow view of its sum.
    always_comb begin
        sum_full   = cur_i + delta_x;
        narrow_off = wide_i ? sum_full[SEG_W-1:0]
                            : {{(SEG_W-HALF_W){1'b0}}, sum_full[HALF_W-1:0]};
    end

    ptr_seg_check #(
        .SEG_W  (SEG_W),
        .HALF_W (HALF_W)
    ) u_seg (
        .offs_i   (narrow_off),
        .limit_i  (limit_i),
        .expdn_i  (expdn_i),
        .wide_i   (wide_i),
        .inside_o (seg_inside)
    );

    ptr_canon_check #(
        .ADDR_W  (ADDR_W),
        .VA_BITS (VA_BITS)
    ) u_canon (
        .addr_i  (sum_full),
        .canon_o (canon)
    );

    // Purpose: choose the returned value, the merged value and the error by mode.
    always_comb begin
        if (mode64_i) begin
            ret_o    = sum_full;
            merged_o = sum_full;
            err_o    = !canon;
        end else begin
            ret_o = {{(ADDR_W-SEG_W){1'b0}}, narrow_off};
            if (wide_i) begin
                merged_o = {cur_i[ADDR_W-1:SEG_W], sum_full[SEG_W-1:0]};
            end else begin
                merged_o = {cur_i[ADDR_W-1:HALF_W], sum_full[HALF_W-1:0]};
            end
            err_o = !seg_inside;
        end
    end
endmodule

// File: rtl/ptr_adjuster.sv
// Module: ptr_adjuster (top)
// Holds the instruction and stack pointer registers. It accepts one adjust
// request per cycle and answers one cycle later with the new value and an
// error flag, committing the value at the same edge when writing is asked
// for and no error was found. Assumes the mode and segment attributes are
// stable during the cycle of a request.
module ptr_adjuster #(
    parameter int ADDR_W  = 64,
    parameter int DELTA_W = 64,
    parameter int SEG_W   = 32,
    parameter int HALF_W  = 16,
    parameter int VA_BITS = 48,
    parameter logic [ADDR_W-1:0] RIP_RST = 64'h0000_0012_0000_1000,
    parameter logic [ADDR_W-1:0] RSP_RST = 64'h0000_0034_0000_8000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               long_mode_i,
    input  logic               cs_long_i,
    input  logic               cs_wide_i,
    input  logic               ss_wide_i,
    input  logic [SEG_W-1:0]   cs_limit_i,
    input  logic               cs_expdn_i,
    input  logic [SEG_W-1:0]   ss_limit_i,
    input  logic               ss_expdn_i,
    input  logic               req_valid_i,
    input  logic               req_sel_i,
    input  logic [DELTA_W-1:0] req_delta_i,
    input  logic               req_wr_i,
    output logic               res_valid_o,
    output logic [ADDR_W-1:0]  res_ptr_o,
    output logic               res_err_o,
    output logic [ADDR_W-1:0]  ip_o,
    output logic [ADDR_W-1:0]  sp_o
);
    import ptr_adj_pkg::*;

    logic [ADDR_W-1:0] ptr_cur [NUM_PTRS];
    logic [ADDR_W-1:0] sel_cur;
    logic              mode64;
    logic              sel_wide;
    logic [SEG_W-1:0]  sel_limit;
    logic              sel_expdn;
    logic [ADDR_W-1:0] calc_ret;
    logic [ADDR_W-1:0] calc_merged;
    logic              calc_err;
    logic              valid_q;
    logic [ADDR_W-1:0] ptr_res_q;
    logic              err_q;

    // Purpose: decode the mode and route the attributes of the selected pointer.
    always_comb begin
        mode64 = long_mode_i && cs_long_i;
        if (ptr_sel_e'(req_sel_i) == PSEL_SP) begin
            sel_cur   = ptr_cur[PSEL_SP];
            sel_wide  = ss_wide_i;
            sel_limit = ss_limit_i;
            sel_expdn = ss_expdn_i;
        end else begin
            sel_cur   = ptr_cur[PSEL_IP];
            sel_wide  = cs_wide_i;
            sel_limit = cs_limit_i;
            sel_expdn = cs_expdn_i;
        end
    end

    ptr_next_calc #(
        .ADDR_W  (ADDR_W),
        .DELTA_W (DELTA_W),
        .SEG_W   (SEG_W),
        .HALF_W  (HALF_W),
        .VA_BITS (VA_BITS)
    ) u_calc (
        .cur_i    (sel_cur),
        .delta_i  (req_delta_i),
        .mode64_i (mode64),
        .wide_i   (sel_wide),
        .limit_i  (sel_limit),
        .expdn_i  (sel_expdn),
        .ret_o    (calc_ret),
        .merged_o (calc_merged),
        .err_o    (calc_err)
    );

    // One register slice per pointer, each with its own reset value and commit.
    for (genvar k = 0; k < NUM_PTRS; k++) begin : g_ptr
        localparam logic [ADDR_W-1:0] RST_VAL = (k == 0) ? RIP_RST : RSP_RST;
        logic [ADDR_W-1:0] val_q;
        logic              commit;

        assign commit     = req_valid_i && req_wr_i && !calc_err && (req_sel_i == 1'(k));
        assign ptr_cur[k] = val_q;

        // Purpose: hold the pointer and take the merged value on a clean commit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= RST_VAL;
            end else if (commit) begin
                val_q <= calc_merged;
            end
        end
    end

    // Purpose: register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            ptr_res_q <= '0;
            err_q     <= 1'b0;
        end else begin
            valid_q <= req_valid_i;
            if (req_valid_i) begin
                ptr_res_q <= calc_ret;
                err_q     <= calc_err;
            end
        end
    end

    assign res_valid_o = valid_q;
    assign res_ptr_o   = ptr_res_q;
    assign res_err_o   = err_q;
    assign ip_o        = ptr_cur[PSEL_IP];
    assign sp_o        = ptr_cur[PSEL_SP];
endmodule

// File: rtl/ptr_adjuster_chk.sv
// Module: ptr_adjuster_chk
// Checker bound to ptr_adjuster. It watches the ports only and relates each
// response to the request and register state of the cycle before.
module ptr_adjuster_chk #(
    parameter int ADDR_W  = 64,
    parameter int DELTA_W = 64,
    parameter int SEG_W   = 32,
    parameter int HALF_W  = 16,
    parameter int VA_BITS = 48
) (
    input logic               clk,
    input logic               rst_n,
    input logic               long_mode_i,
    input logic               cs_long_i,
    input logic               cs_wide_i,
    input logic [SEG_W-1:0]   cs_limit_i,
    input logic               cs_expdn_i,
    input logic               req_valid_i,
    input logic               req_sel_i,
    input logic               req_wr_i,
    input logic               res_valid_o,
    input logic [ADDR_W-1:0]  res_ptr_o,
    input logic               res_err_o,
    input logic [ADDR_W-1:0]  ip_o,
    input logic [ADDR_W-1:0]  sp_o
);
    localparam int HI_W = ADDR_W - VA_BITS + 1;

    a_r1_resp_latency: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o == $past(req_valid_i));

    a_r3_canon_result: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_err_o && $past(long_mode_i && cs_long_i))
        |-> ($countones(res_ptr_o[ADDR_W-1:VA_BITS-1]) == 0 ||
             $countones(res_ptr_o[ADDR_W-1:VA_BITS-1]) == HI_W));

    a_r4_ip_half_width: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && $past(!(long_mode_i && cs_long_i) && !req_sel_i && !cs_wide_i))
        |-> (res_ptr_o[ADDR_W-1:HALF_W] == '0));

    a_r6_ip_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_err_o &&
         $past(!(long_mode_i && cs_long_i) && !req_sel_i && !cs_expdn_i))
        |-> (res_ptr_o[SEG_W-1:0] <= $past(cs_limit_i)));

    a_r8_ip_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && $past(!(long_mode_i && cs_long_i) && !req_sel_i))
        |-> (ip_o[ADDR_W-1:SEG_W] == $past(ip_o[ADDR_W-1:SEG_W])));

    a_r8_ip_commit64: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_err_o && $past(long_mode_i && cs_long_i && req_wr_i && !req_sel_i))
        |-> (ip_o == res_ptr_o));

    a_r9_error_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_err_o) |-> ($stable(ip_o) && $stable(sp_o)));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> ($stable(ip_o) && $stable(sp_o)));
endmodule

bind ptr_adjuster ptr_adjuster_chk #(
    .ADDR_W  (ADDR_W),
    .DELTA_W (DELTA_W),
    .SEG_W   (SEG_W),
    .HALF_W  (HALF_W),
    .VA_BITS (VA_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .long_mode_i (long_mode_i),
    .cs_long_i   (cs_long_i),
    .cs_wide_i   (cs_wide_i),
    .cs_limit_i  (cs_limit_i),
    .cs_expdn_i  (cs_expdn_i),
    .req_valid_i (req_valid_i),
    .req_sel_i   (req_sel_i),
    .req_wr_i    (req_wr_i),
    .res_valid_o (res_valid_o),
    .res_ptr_o   (res_ptr_o),
    .res_err_o   (res_err_o),
    .ip_o        (ip_o),
    .sp_o        (sp_o)
);

// File: tb/ptr_adjuster_bench.sv
// Scoreboard bench for ptr_adjuster. The driver task computes the expected
// response and register values from the requirements and queues them. The
// monitor compares them at the falling edge after each response.
module ptr_adjuster_bench;
    localparam logic [63:0] IP0 = 64'h0000_0012_0000_1000;
    localparam logic [63:0] SP0 = 64'h0000_0034_0000_8000;

    typedef struct {
        logic [63:0] ptr;
        logic        err;
        logic [63:0] ip_after;
        logic [63:0] sp_after;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lm = 1'b0, cl = 1'b0, csw = 1'b1, ssw = 1'b1;
    logic [31:0] cs_lim = 32'h0000_FFFF, ss_lim = 32'h0000_0FFF;
    logic        cs_ed = 1'b0, ss_ed = 1'b1;
    logic        rv = 1'b0, rsel = 1'b0, rwr = 1'b0;
    logic [63:0] rdelta = '0;
    logic        res_valid, res_err;
    logic [63:0] res_ptr, ip, sp;

    logic [63:0] m_ip = IP0;
    logic [63:0] m_sp = SP0;
    item_t       sb[$];
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    ptr_adjuster #(.RIP_RST(IP0), .RSP_RST(SP0)) u_ptr_adjuster (
        .clk(clk), .rst_n(rst_n), .long_mode_i(lm), .cs_long_i(cl),
        .cs_wide_i(csw), .ss_wide_i(ssw), .cs_limit_i(cs_lim), .cs_expdn_i(cs_ed),
        .ss_limit_i(ss_lim), .ss_expdn_i(ss_ed), .req_valid_i(rv), .req_sel_i(rsel),
        .req_delta_i(rdelta), .req_wr_i(rwr), .res_valid_o(res_valid),
        .res_ptr_o(res_ptr), .res_err_o(res_err), .ip_o(ip), .sp_o(sp));

    task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Expected behaviour straight from the requirements.
    task automatic send(input logic sel, input logic [63:0] delta, input logic wr, input string tag);
        item_t       it;
        logic [63:0] cur, full;
        logic [31:0] off, top, lim;
        logic        wide, ed;
        @(negedge clk);
        rv = 1'b1; rsel = sel; rdelta = delta; rwr = wr;
        cur = sel ? m_sp : m_ip;
        if (lm && cl) begin                          // R2, R3
            full   = cur + delta;
            it.ptr = full;
            it.err = !((full[63:47] == 17'h0) || (full[63:47] == 17'h1FFFF));
        end else begin                               // R4 to R7
            wide = sel ? ssw : csw;
            lim  = sel ? ss_lim : cs_lim;
            ed   = sel ? ss_ed : cs_ed;
            if (wide) begin
                off = cur[31:0] + delta[31:0];
                top = 32'hFFFF_FFFF;
                full = {cur[63:32], off};
            end else begin
                off = {16'h0, cur[15:0] + delta[15:0]};
                top = 32'h0000_FFFF;
                full = {cur[63:16], off[15:0]};
            end
            it.ptr = {32'h0, off};
            it.err = ed ? !((off > lim) && (off <= top)) : (off > lim);
        end
        if (wr && !it.err) begin                     // R8, R9
            if (sel) m_sp = full; else m_ip = full;
        end
        it.ip_after = m_ip;
        it.sp_after = m_sp;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rv = 1'b0;
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Monitor: pop one expected item per response, flag unexpected responses.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb.size() == 0) begin
                cmp("R1", "unexpected response", 64'd1, 64'd0);
            end else begin
                item_t e;
                e = sb.pop_front();
                cmp(e.tag, "res_ptr", res_ptr, e.ptr);
                cmp(e.tag, "res_err", {63'h0, res_err}, {63'h0, e.err});
                cmp(e.tag, "ip", ip, e.ip_after);
                cmp(e.tag, "sp", sp, e.sp_after);
            end
        end
    end

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R10", "ip reset", ip, IP0);
        cmp("R10", "sp reset", sp, SP0);
        cmp("R10", "valid reset", {63'h0, res_valid}, 64'h0);

        // Legacy 32-bit instruction pointer, normal segment.
        send(1'b0, 64'h20, 1'b1, "R4_R8 ip up");
        send(1'b0, -64'sd16, 1'b1, "R4 ip negative");
        send(1'b0, 64'h1_0000, 1'b1, "R6_R9 ip over limit");
        send(1'b0, 64'h4, 1'b0, "R9 no write");
        idle(2);
        cs_lim = 32'h0000_2000;
        send(1'b0, {32'h0, 32'h2000 - m_ip[31:0]}, 1'b1, "R6 ip at limit");
        send(1'b0, 64'h1, 1'b1, "R6 ip limit plus one");
        idle(1);

        // Stack pointer, 32-bit expand-down, limit 0xFFF.
        send(1'b1, -64'sd28672, 1'b1, "R7 sp lowest valid");
        send(1'b1, -64'sd1, 1'b1, "R7 sp at limit");
        send(1'b1, -64'sd8192, 1'b1, "R5_R7 sp wraps 32");
        idle(1);
        ssw = 1'b0;
        send(1'b1, 64'h1000, 1'b1, "R5_R7 sp wraps 16 to zero");
        send(1'b1, 64'h0FFF, 1'b1, "R5_R7_R8 sp top 16");
        send(1'b1, 64'h1, 1'b1, "R7 sp past top");
        idle(1);

        // 16-bit instruction pointer wrap.
        csw = 1'b0; cs_lim = 32'h0000_FFFF;
        send(1'b0, 64'hF000, 1'b1, "R4 ip wraps 16");
        send(1'b0, 64'h0001_0003, 1'b1, "R4_R8 ip low half only");
        idle(1);

        // Compatibility: long mode without 64-bit code.
        lm = 1'b1; csw = 1'b1;
        send(1'b0, 64'h8, 1'b1, "R2 compat narrow");
        idle(1);

        // 64-bit operation.
        cl = 1'b1;
        send(1'b0, 64'h0000_7FFF_FFFF_F000 - m_ip, 1'b1, "R2_R8 ip full 64");
        send(1'b0, 64'h1000, 1'b1, "R3 ip non canonical");
        send(1'b0, 64'hFFFF_8000_0000_0000 - m_ip, 1'b1, "R3 ip high half");
        send(1'b1, 64'h0 - m_sp - 64'h1, 1'b1, "R2 sp negative 64");
        send(1'b1, 64'h0000_0000_0001_0000, 1'b0, "R9 sp no write 64");
        idle(1);

        // Back to legacy: upper bits of a 64-bit value survive a narrow write.
        lm = 1'b0; cl = 1'b0; cs_lim = 32'hFFFF_FFFF; ssw = 1'b1; ss_ed = 1'b0; ss_lim = 32'hFFFF_FFFF;
        send(1'b0, 64'h10, 1'b1, "R8 upper kept ip");
        send(1'b1, 64'h10, 1'b1, "R8 upper kept sp");
        idle(4);

        cmp("R1", "responses outstanding", 64'(sb.size()), 64'h0);
        done = 1'b1;
        report();
    end
endmodule